// File: doc/BRIEF.md
# Printer Port Host Register Block

This block gives a host a byte-wide register view of a classic printer port: an output data latch, a status register and a control register, reached over a small single-cycle register bus. The low three bits of the bus address select the register, and every higher address bit is ignored. Because no real printer sits behind the block, it carries its own model of the printer handshake. Control writes step that model through its init, select and strobe bits, and status reads step its acknowledge and busy bits, so a driver can run its usual strobe, busy and acknowledge loop unchanged.

Each rising edge of the stored strobe bit sends the output latch out on a valid/ready byte stream. A level interrupt output reports the pending flag, which is raised by the strobe-release path when interrupts are enabled and is cleared by a status read. The input data pins pass through a parameterized synchronizer into an input latch. A data read returns either that input latch or the output latch, depending on the direction bit.

Top module: `pp_host_regs`

## Requirements
- R1: The register is chosen by address bits 2:0. Offset 0 is data, offset 1 is status and offset 2 is control. A read of offsets 3 to 7 returns 0xFF. A write to offsets 1 or 3 to 7 changes no register.
- R2: After reset, the output and input latches hold 0xFF, status reads 0xD9, control reads 0xCC, irq_o is 0 and tx_valid_o is 0.
- R3: A control write stores the written byte with bits 7:6 forced to 1. Control bits are: 5 direction (1 = input), 4 interrupt enable, 3 select, 2 init, 1 auto linefeed, 0 strobe.
- R4: A control write with init (bit 2) = 0 loads status with 0xD8, which is busy bit 7, acknowledge bit 6, online bit 4 and error bit 3 set.
- R5: A control write with init = 1, select = 1 and strobe = 1 clears status bit 7. It emits the output latch on the byte stream only if the previously stored strobe was 0.
- R6: A control write with init = 1, select = 1 and strobe = 0 sets the pending flag when the previously stored control had bit 4 set. irq_o equals the pending flag from the cycle after the write.
- R7: A status read returns the current status and clears the pending flag. If status bit 7 and the stored strobe are both 0, the read then clears bit 6 when bit 6 was set, or sets bits 6 and 7 when bit 6 was clear.
- R8: A data read returns the input latch when control bit 5 is 1, and the output latch when it is 0. The input latch follows the pins after SYNC_STAGES clock cycles.
- R9: An emitted byte is held on tx_data_o with tx_valid_o high until tx_ready_i accepts it. A new emit while an unaccepted byte is held overwrites that byte and sets tx_overflow_o, which stays set until reset.
- R10: Read side effects occur only in a cycle with bus_rd_i high and bus_wr_i low. When both strobes are high, only the write takes effect.
- R11: A control write with init = 1 and select = 0 leaves status unchanged and emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | BUS_AW | Register bus address; only bits 2:0 decode |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 8 | Read data, valid in the cycle of bus_rd_i |
| pin_data_i | input | 8 | Data pins sampled into the input latch |
| irq_o | output | 1 | Level interrupt, equal to the pending flag |
| tx_data_o | output | 8 | Emitted byte |
| tx_valid_o | output | 1 | Emitted byte valid |
| tx_ready_i | input | 1 | Consumer accepts the byte |
| tx_overflow_o | output | 1 | Sticky flag: a byte was overwritten before acceptance |

## Verification
The bench uses the defaults BUS_AW = 8 and SYNC_STAGES = 2. The wide address lets it read control through an aliased address with a high bit set. The two-stage synchronizer gives a real delay between a pin change and the data read under input direction. The scoreboard covers the full ack/busy stepping cycle, a strobe held high with no second emit, a back-pressured stream that overwrites a byte, and a read issued together with a write.

// File: rtl/pp_pkg.sv
package pp_pkg;

    localparam int REG_W = 8;

    // register offsets (software decodes these)
    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_STAT = 3'd1;
    localparam logic [2:0] OFS_CTRL = 3'd2;

    // status bit positions
    localparam int ST_BUSY   = 7;
    localparam int ST_ACK    = 6;
    localparam int ST_PAPER  = 5;
    localparam int ST_ONLINE = 4;
    localparam int ST_ERR    = 3;
    localparam int ST_TMO    = 0;

    // control bit positions
    localparam int CT_DIR  = 5;
    localparam int CT_IEN  = 4;
    localparam int CT_SEL  = 3;
    localparam int CT_INIT = 2;
    localparam int CT_ALF  = 1;
    localparam int CT_STB  = 0;

    localparam logic [REG_W-1:0] STAT_RST   = 8'hD9;
    localparam logic [REG_W-1:0] CTRL_RST   = 8'hCC;
    localparam logic [REG_W-1:0] LATCH_RST  = 8'hFF;
    localparam logic [REG_W-1:0] STAT_INIT  = 8'hD8;
    localparam logic [REG_W-1:0] CTRL_FORCE = 8'hC0;
    localparam logic [REG_W-1:0] OPEN_BUS   = 8'hFF;

    typedef struct packed {
        logic [REG_W-1:0] dout;
        logic [REG_W-1:0] stat;
        logic [REG_W-1:0] ctrl;
        logic             pend;
        logic             emit;
    } core_st_t;

    typedef struct packed {
        logic [REG_W-1:0] data;
        logic             valid;
        logic             ovf;
    } strm_st_t;

endpackage

// File: rtl/pp_in_sync.sv
module pp_in_sync
    import pp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] pins_i,
    output logic [REG_W-1:0] latch_o
);
    localparam int NST = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

    logic [REG_W-1:0] stage_q [NST];

    generate
        for (genvar g = 0; g < NST; g++) begin : g_stage
            logic [REG_W-1:0] stage_d;
            if (g == 0) begin : g_first
                assign stage_d = pins_i;
            end else begin : g_next
                assign stage_d = stage_q[g-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= LATCH_RST;
                else        stage_q[g] <= stage_d;
            end
        end
    endgenerate

    assign latch_o = stage_q[NST-1];

endmodule

// File: rtl/pp_port_core.sv
module pp_port_core
    import pp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       ofs_i,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             rd_i,
    output core_st_t         st_o
);
    core_st_t st_d, st_q;
    logic [REG_W-1:0] cval;
    logic             wr_act;
    logic             rd_act;

    always_comb begin
        st_d      = st_q;
        st_d.emit = 1'b0;
        wr_act    = wr_i;
        rd_act    = rd_i && !wr_i;
        cval      = wdata_i | CTRL_FORCE;

        if (wr_act) begin
            unique case (ofs_i)
                OFS_DATA: st_d.dout = wdata_i;
                OFS_CTRL: begin
                    if (!cval[CT_INIT]) begin
                        st_d.stat = STAT_INIT;
                    end else if (cval[CT_SEL]) begin
                        if (cval[CT_STB]) begin
                            st_d.stat[ST_BUSY] = 1'b0;
                            if (!st_q.ctrl[CT_STB]) st_d.emit = 1'b1;
                        end else if (st_q.ctrl[CT_IEN]) begin
                            st_d.pend = 1'b1;
                        end
                    end
                    st_d.ctrl = cval;
                end
                default: ;
            endcase
        end

        if (rd_act && ofs_i == OFS_STAT) begin
            st_d.pend = 1'b0;
            if (!st_q.stat[ST_BUSY] && !st_q.ctrl[CT_STB]) begin
                if (st_q.stat[ST_ACK]) begin
                    st_d.stat[ST_ACK] = 1'b0;
                end else begin
                    st_d.stat[ST_ACK]  = 1'b1;
                    st_d.stat[ST_BUSY] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dout <= LATCH_RST;
            st_q.stat <= STAT_RST;
            st_q.ctrl <= CTRL_RST;
            st_q.pend <= 1'b0;
            st_q.emit <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st_o = st_q;

    a_r4_init_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && ofs_i == OFS_CTRL && !wdata_i[CT_INIT]) |=> st_q.stat == STAT_INIT);

    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !wr_i && ofs_i == OFS_STAT) |=> !st_q.pend);

    a_r6_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && ofs_i == OFS_CTRL && wdata_i[CT_INIT] && wdata_i[CT_SEL]
         && !wdata_i[CT_STB] && st_q.ctrl[CT_IEN]) |=> st_q.pend);

    a_r5_emit_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.emit |-> (st_q.ctrl[CT_STB] && !st_q.stat[ST_BUSY]));

    a_r3_ctrl_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && ofs_i == OFS_CTRL) |=> st_q.ctrl[7:6] == 2'b11);

endmodule

// File: rtl/pp_stream_out.sv
module pp_stream_out
    import pp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [REG_W-1:0] byte_i,
    input  logic             ready_i,
    output logic [REG_W-1:0] data_o,
    output logic             valid_o,
    output logic             ovf_o
);
    strm_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.valid && ready_i) st_d.valid = 1'b0;
        if (load_i) begin
            st_d.data  = byte_i;
            st_d.valid = 1'b1;
            if (st_q.valid && !ready_i) st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.data  <= '0;
            st_q.valid <= 1'b0;
            st_q.ovf   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o  = st_q.data;
    assign valid_o = st_q.valid;
    assign ovf_o   = st_q.ovf;

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i && !load_i) |=> (valid_o && $stable(data_o)));

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

endmodule

// File: rtl/pp_read_mux.sv
module pp_read_mux
    import pp_pkg::*;
(
    input  logic [2:0]       ofs_i,
    input  core_st_t         st_i,
    input  logic [REG_W-1:0] din_i,
    output logic [REG_W-1:0] rdata_o
);
    always_comb begin
        unique case (ofs_i)
            OFS_DATA: rdata_o = st_i.ctrl[CT_DIR] ? din_i : st_i.dout;
            OFS_STAT: rdata_o = st_i.stat;
            OFS_CTRL: rdata_o = st_i.ctrl;
            default:  rdata_o = OPEN_BUS;
        endcase
    end
endmodule

// File: rtl/pp_host_regs.sv
module pp_host_regs
    import pp_pkg::*;
#(
    parameter int BUS_AW      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [7:0]        bus_wdata_i,
    input  logic              bus_rd_i,
    output logic [7:0]        bus_rdata_o,
    input  logic [7:0]        pin_data_i,
    output logic              irq_o,
    output logic [7:0]        tx_data_o,
    output logic              tx_valid_o,
    input  logic              tx_ready_i,
    output logic              tx_overflow_o
);
    logic [2:0]       ofs;
    core_st_t         core_st;
    logic [REG_W-1:0] din_latch;

    assign ofs = bus_addr_i[2:0];

    pp_in_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_i  (pin_data_i),
        .latch_o (din_latch)
    );

    pp_port_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .ofs_i   (ofs),
        .wr_i    (bus_wr_i),
        .wdata_i (bus_wdata_i),
        .rd_i    (bus_rd_i),
        .st_o    (core_st)
    );

    pp_read_mux u_rmux (
        .ofs_i   (ofs),
        .st_i    (core_st),
        .din_i   (din_latch),
        .rdata_o (bus_rdata_o)
    );

    pp_stream_out u_strm (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (core_st.emit),
        .byte_i  (core_st.dout),
        .ready_i (tx_ready_i),
        .data_o  (tx_data_o),
        .valid_o (tx_valid_o),
        .ovf_o   (tx_overflow_o)
    );

    assign irq_o = core_st.pend;

    a_r10_dual_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_rd_i && ofs == OFS_STAT) |=> $stable(core_st.stat));

endmodule

// File: tb/pp_host_regs_tb.sv
module pp_host_regs_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_data = 8'h00;
    logic       irq;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b1;
    logic       tx_ovf;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] exp_q [$];
    logic [7:0] rv;

    always #10 clk = ~clk;

    pp_host_regs #(.BUS_AW(8), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr), .bus_wr_i(bus_wr),
        .bus_wdata_i(bus_wdata), .bus_rd_i(bus_rd), .bus_rdata_o(bus_rdata),
        .pin_data_i(pin_data), .irq_o(irq), .tx_data_o(tx_data),
        .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_overflow_o(tx_ovf)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    // driver side of the scoreboard: replace models an overwrite
    task automatic expect_byte(input logic [7:0] b, input bit replace);
        if (replace && exp_q.size() > 0) exp_q[exp_q.size()-1] = b;
        else exp_q.push_back(b);
    endtask

    // monitor: compare each accepted byte against the queue
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
                check("R5 unexpected byte", tx_data, 8'h00);
            end else begin
                check("R5/R9 stream byte", tx_data, exp_q[0]);
                void'(exp_q.pop_front());
            end
        end
    end

    initial begin
        #1_000_000;
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        idle(2);
        rst_n = 1'b1;
        idle(1);
        // R2 reset state
        check("R2 irq", {7'd0, irq}, 8'h00);
        check("R2 tx_valid", {7'd0, tx_valid}, 8'h00);
        rd(8'h01, rv); check("R2 status", rv, 8'hD9);
        rd(8'h02, rv); check("R2 control", rv, 8'hCC);
        rd(8'h00, rv); check("R2 data", rv, 8'hFF);
        // R1 decode, open offsets, alias
        for (int a = 3; a < 8; a++) begin
            rd(8'(a), rv); check("R1 open offset", rv, 8'hFF);
        end
        rd(8'hAA, rv); check("R1 alias control", rv, 8'hCC);
        // R5 strobe emits output latch
        wr(8'h00, 8'h41);
        rd(8'h00, rv); check("R8 output latch", rv, 8'h41);
        expect_byte(8'h41, 1'b0);
        wr(8'h02, 8'h0D);
        rd(8'h02, rv); check("R3 control readback", rv, 8'hCD);
        rd(8'h01, rv); check("R5 busy cleared", rv, 8'h59);
        rd(8'h01, rv); check("R7 no step with strobe high", rv, 8'h59);
        // R7 stepping, R10 side effects need rd strobe
        wr(8'h02, 8'h0C);
        check("R6 no irq without prior enable", {7'd0, irq}, 8'h00);
        bus_addr = 8'h01; idle(3);
        rd(8'h01, rv); check("R10 idle address no effect", rv, 8'h59);
        bus_addr = 8'h01; bus_wdata = 8'h00; bus_wr = 1'b1; bus_rd = 1'b1;
        @(posedge clk); #1; bus_wr = 1'b0; bus_rd = 1'b0;
        rd(8'h01, rv); check("R10 dual strobe write only", rv, 8'h19);
        rd(8'h01, rv); check("R7 ack and busy set", rv, 8'hD9);
        // second emit, then strobe held high emits nothing
        wr(8'h00, 8'h42);
        expect_byte(8'h42, 1'b0);
        wr(8'h02, 8'h0D);
        wr(8'h02, 8'h0F);
        idle(4);
        check("R5 no emit when strobe already high", 8'(exp_q.size()), 8'h00);
        check("R5 stream idle", {7'd0, tx_valid}, 8'h00);
        // R6 interrupt
        wr(8'h02, 8'h1C);
        check("R6 enable first write no irq", {7'd0, irq}, 8'h00);
        wr(8'h02, 8'h1C);
        check("R6 irq pending", {7'd0, irq}, 8'h01);
        wr(8'h00, 8'h55);
        check("R6 irq held over data write", {7'd0, irq}, 8'h01);
        rd(8'h01, rv); check("R7 status read value", rv, 8'h59);
        check("R7 read clears irq", {7'd0, irq}, 8'h00);
        rd(8'h01, rv); check("R7 ack cleared", rv, 8'h19);
        // R4 init
        wr(8'h02, 8'h18);
        rd(8'h01, rv); check("R4 init loads status", rv, 8'hD8);
        rd(8'h02, rv); check("R3 forced top bits", rv, 8'hD8);
        // R11 select low
        wr(8'h02, 8'h05);
        idle(3);
        rd(8'h01, rv); check("R11 status unchanged", rv, 8'hD8);
        check("R11 no emit", {7'd0, tx_valid}, 8'h00);
        // R1 write to status ignored
        wr(8'h01, 8'h00);
        wr(8'h07, 8'h00);
        rd(8'h01, rv); check("R1 status write ignored", rv, 8'hD8);
        rd(8'h02, rv); check("R1 offset 7 write ignored", rv, 8'hC5);
        // R8 direction
        pin_data = 8'h3C;
        wr(8'h02, 8'h24);
        idle(3);
        rd(8'h00, rv); check("R8 input latch", rv, 8'h3C);
        wr(8'h02, 8'h04);
        rd(8'h00, rv); check("R8 output latch back", rv, 8'h55);
        // R9 overflow under back-pressure
        tx_ready = 1'b0;
        wr(8'h00, 8'h11);
        wr(8'h02, 8'h0C);
        expect_byte(8'h11, 1'b0);
        wr(8'h02, 8'h0D);
        idle(2);
        check("R9 held valid", {7'd0, tx_valid}, 8'h01);
        check("R9 no overflow yet", {7'd0, tx_ovf}, 8'h00);
        wr(8'h02, 8'h0C);
        wr(8'h00, 8'h22);
        expect_byte(8'h22, 1'b1);
        wr(8'h02, 8'h0D);
        idle(2);
        check("R9 overflow set", {7'd0, tx_ovf}, 8'h01);
        check("R9 overwritten byte", tx_data, 8'h22);
        tx_ready = 1'b1;
        idle(3);
        check("R9 queue drained", 8'(exp_q.size()), 8'h00);
        check("R9 overflow sticky", {7'd0, tx_ovf}, 8'h01);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule